// File: doc/BRIEF.md
# SPI Register Slave with Command Parity Check

This block is an SPI slave that lets an external master read and write a 64-entry, byte-wide register file. It runs entirely in the system clock domain. The serial clock, chip select and data-in pins each pass through a two-flop synchronizer. The block then finds the serial clock edges by comparing successive synchronized samples. The bus uses clock-idle-high timing: the master changes data on the falling edge and samples it on the rising edge. The slave updates its data-out on each falling edge. The serial clock may run at most at one eighth of the system clock, so that the data-out bit is settled before the next rising edge.

Each transaction starts with a command byte. Bit 7 gives the direction. Bits 5:0 give the register address. Bit 6 is a flag whose meaning depends on a two-bit parity mode held in a control register at address 0x3F. The flag either controls how the address moves during a burst, or carries even or odd parity over bits 6:0. Data bytes follow in steps of 8 clocks. A command that fails its parity check sets a sticky error flag, and that flag is also driven on a pin. A write carried by a failing command changes no register.

Top module: `spi_regslave`

## Requirements
- R1: Command bit 7 = 1 means read and 0 means write; bits 5:0 are the start address. A single-register access takes 16 serial clock pulses. For a read, data-out carries the byte MSB first, and each bit changes after a falling edge.
- R2: With parity mode 00 or 11, command bit 6 = 0 makes the address advance by one after every data byte, and bit 6 = 1 keeps every data byte on the same register.
- R3: An advancing address wraps from 0x3F to 0x00.
- R4: Parity mode 01 is even parity and mode 10 is odd parity. In both, the check covers command bits 6:0 and not bit 7, and the address always advances during a burst. Examples: 0x40 is a good odd-parity write to 0x00, 0xE0 a good even-parity read of 0x20, 0xA3 a good odd-parity read of 0x23, and 0xBF a good even-parity read of 0x3F.
- R5: A command whose parity bit mismatches sets parity_err. The flag stays set until a write to the control register with data bit 0 = 1; a write with bit 0 = 0 leaves it set.
- R6: A write whose command fails the parity check modifies no register. A read whose command fails the check still returns the addressed data.
- R7: The control register at 0x3F reads as {5'b0, mode[1:0] in bits 2:1, parity_err in bit 0}. A write loads the mode from data bits 2:1.
- R8: Chip select going high ends the transaction and discards any partial byte. Data-out is 0 while chip select is high.
- R9: After reset, all registers read 0, the mode is 00, parity_err is 0 and data-out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| parity_err | output | 1 | Sticky command parity error flag |

## Verification
The hardest case to reach is a rejected write that must leave its target register untouched. Getting there means first switching the parity mode through the same serial port, using a command that is valid under the old mode. Then a command with its flag bit deliberately inverted is sent, and the target is read back with a correctly formed command. The bench follows each mode change in its own copy of the mode, and builds every command from that copy. It then drives the flag wrong on purpose, and also covers clearing the flag, a burst read that runs through the control register as it wraps, and a transaction cut off mid-byte.

// File: rtl/spisl_pkg.sv
package spisl_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 6;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int DIR_BIT  = 7;
  localparam int FLAG_BIT = 6;

  typedef enum logic [1:0] {
    PM_STEP     = 2'b00,
    PM_EVEN     = 2'b01,
    PM_ODD      = 2'b10,
    PM_STEP_ALT = 2'b11
  } par_mode_e;

  // 1 when the command fields bits 6:0 fail the check of the given mode
  function automatic logic parity_bad(par_mode_e m, logic [FLAG_BIT:0] f);
    case (m)
      PM_EVEN: return ^f;
      PM_ODD:  return ~(^f);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic flag_is_hold(par_mode_e m);
    return (m == PM_STEP) || (m == PM_STEP_ALT);
  endfunction
endpackage

// File: rtl/spisl_sync.sv
module spisl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spisl_engine.sv
module spisl_engine
  import spisl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  par_mode_e         mode,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_set,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr, tx_sr, rx_byte;
  logic              in_data, is_rd, hold, bad;
  logic [ADDR_W-1:0] addr, nxt_addr;
  logic              rise, fall, byte_end, cmd_done, data_done, cmd_fail;

  assign rise      = sclk_s & ~sclk_q & ~csn_s;
  assign fall      = ~sclk_s & sclk_q & ~csn_s;
  assign rx_byte   = {rx_sr[DATA_W-2:0], mosi_s};
  assign byte_end  = rise & (bit_cnt == CNT_W'(DATA_W - 1));
  assign cmd_done  = byte_end & ~in_data;
  assign data_done = byte_end & in_data;
  assign nxt_addr  = hold ? addr : addr + ADDR_W'(1);
  assign rd_addr   = in_data ? nxt_addr : rx_byte[ADDR_W-1:0];
  assign cmd_fail  = parity_bad(mode, rx_byte[FLAG_BIT:0]);

  assign wr_en   = data_done & ~is_rd & ~bad;
  assign wr_addr = addr;
  assign wr_data = rx_byte;
  assign err_set = cmd_done & cmd_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      in_data <= 1'b0;
      is_rd   <= 1'b0;
      hold    <= 1'b0;
      bad     <= 1'b0;
      addr    <= '0;
      miso    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (csn_s) begin
        bit_cnt <= '0;
        in_data <= 1'b0;
        tx_sr   <= '0;
        miso    <= 1'b0;
      end else if (rise) begin
        rx_sr   <= rx_byte;
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (cmd_done) begin
          in_data <= 1'b1;
          is_rd   <= rx_byte[DIR_BIT];
          addr    <= rx_byte[ADDR_W-1:0];
          bad     <= cmd_fail;
          hold    <= flag_is_hold(mode) & rx_byte[FLAG_BIT];
          if (rx_byte[DIR_BIT]) tx_sr <= rd_data;
        end else if (data_done) begin
          addr <= nxt_addr;
          if (is_rd) tx_sr <= rd_data;
        end
      end else if (fall) begin
        miso  <= tx_sr[DATA_W-1];
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spisl_regs.sv
module spisl_regs
  import spisl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              err_set,
  output logic [DATA_W-1:0] rd_data,
  output par_mode_e         mode,
  output logic              parity_err
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              ctrl_wr;

  assign ctrl_wr = wr_en & (wr_addr == CTRL_ADDR);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))      mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= PM_STEP;
      parity_err <= 1'b0;
    end else begin
      if (ctrl_wr) mode <= par_mode_e'(wr_data[2:1]);
      if (err_set)                     parity_err <= 1'b1;
      else if (ctrl_wr && wr_data[0])  parity_err <= 1'b0;
    end
  end

  assign rd_data = (rd_addr == CTRL_ADDR)
                 ? {{(DATA_W-3){1'b0}}, mode, parity_err}
                 : mem[rd_addr];
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spisl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h3F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic parity_err
);
  logic [2:0]        sync_q;
  par_mode_e         mode;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en, err_set;

  spisl_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_csn, spi_mosi}),
    .q     (sync_q)
  );

  spisl_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sync_q[2]),
    .csn_s   (sync_q[1]),
    .mosi_s  (sync_q[0]),
    .mode    (mode),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .err_set (err_set),
    .miso    (spi_miso)
  );

  spisl_regs #(.CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .err_set    (err_set),
    .rd_data    (rd_data),
    .mode       (mode),
    .parity_err (parity_err)
  );
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_s,
  input logic csn_s,
  input logic wr_en,
  input logic err_set,
  input logic spi_miso,
  input logic parity_err
);
  logic sclk_prev;
  logic fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= sclk_s;
  end
  assign fall_seen = ~sclk_s & sclk_prev & ~csn_s;

  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !spi_miso);

  p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> $past(fall_seen || csn_s));

  p_err_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> parity_err);

  p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(err_set));

  p_err_clear_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err) |-> $past(wr_en));
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_s     (sync_q[2]),
  .csn_s      (sync_q[1]),
  .wr_en      (wr_en),
  .err_set    (err_set),
  .spi_miso   (spi_miso),
  .parity_err (parity_err)
);

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
  logic miso, perr;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [1:0] cur_mode = 2'b00;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always #10 clk = ~clk;

  spi_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso), .parity_err(perr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // build a well-formed command under the bench's view of the mode
  function automatic logic [7:0] mk(input logic rd, input logic [5:0] a, input logic hold);
    logic f;
    case (cur_mode)
      2'b01:   f = ^a;
      2'b10:   f = ~(^a);
      default: f = hold;
    endcase
    return {rd, f, a};
  endfunction

  task automatic shift_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int n);
    logic [7:0] r;
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
    shift_byte(cmd, r);
    for (int k = 0; k < n; k++) begin
      shift_byte(wbuf[k], r);
      rbuf[k] = r;
    end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
    wbuf[0] = d; xfer(cmd, 1);
  endtask

  task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
    wbuf[0] = 8'h00; xfer(cmd, 1); d = rbuf[0];
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R9 parity_err after reset", perr, 0);
    chk("R9 miso after reset", miso, 0);
    rd1(mk(1, 6'h3F, 0), d);
    chk("R7 control reset value", d, 8'h00);
    rd1(mk(1, 6'h05, 0), d);
    chk("R9 register reset value", d, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr1(mk(0, 6'h05, 0), 8'hA5);
    rd1(mk(1, 6'h05, 0), d);
    chk("R1 single write/read", d, 8'hA5);
    chk("R8 miso idle after transfer", miso, 0);
  endtask

  task automatic t_burst_step();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(mk(0, 6'h10, 0), 3);
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    xfer(mk(1, 6'h10, 0), 3);
    chk("R2 burst step byte0", rbuf[0], 8'h11);
    chk("R2 burst step byte1", rbuf[1], 8'h22);
    chk("R2 burst step byte2", rbuf[2], 8'h33);
  endtask

  task automatic t_burst_hold();
    logic [7:0] d;
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    xfer(mk(0, 6'h20, 1), 3);
    rd1(mk(1, 6'h20, 0), d);
    chk("R2 hold keeps last byte", d, 8'h66);
    rd1(mk(1, 6'h21, 0), d);
    chk("R2 hold leaves neighbour", d, 8'h00);
    wr1(mk(0, 6'h3F, 0), 8'h06); cur_mode = 2'b11;
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    xfer(mk(0, 6'h22, 1), 2);
    rd1(mk(1, 6'h22, 0), d);
    chk("R2 mode 11 hold", d, 8'h88);
    rd1(mk(1, 6'h23, 0), d);
    chk("R2 mode 11 neighbour", d, 8'h00);
    wr1(mk(0, 6'h3F, 0), 8'h00); cur_mode = 2'b00;
  endtask

  task automatic t_wrap();
    wr1(mk(0, 6'h3E, 0), 8'h9C);
    wr1(mk(0, 6'h00, 0), 8'h5A);
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    xfer(mk(1, 6'h3E, 0), 3);
    chk("R3 wrap byte 0x3E", rbuf[0], 8'h9C);
    chk("R3 wrap control 0x3F", rbuf[1], 8'h00);
    chk("R3 wrap to 0x00", rbuf[2], 8'h5A);
  endtask

  task automatic t_even();
    logic [7:0] d;
    wr1(8'h3F, 8'h02); cur_mode = 2'b01;
    rd1(8'hE0, d);
    chk("R4 even read 0xE0", d, 8'h66);
    chk("R4 even good no error", perr, 0);
    rd1(8'hBF, d);
    chk("R7 control shows even mode", d, 8'h02);
    wr1(8'h45, 8'h00);
    chk("R5 bad parity sets flag", perr, 1);
    rd1(mk(1, 6'h05, 0), d);
    chk("R6 bad write suppressed", d, 8'hA5);
    rd1(8'h90, d);
    chk("R6 bad read returns data", d, 8'h11);
    wr1(8'h3F, 8'h02);
    chk("R5 write bit0=0 keeps flag", perr, 1);
    wr1(8'h3F, 8'h05); cur_mode = 2'b10;
    chk("R5 write bit0=1 clears flag", perr, 0);
  endtask

  task automatic t_odd();
    logic [7:0] d;
    wr1(8'h40, 8'hC3);
    rd1(mk(1, 6'h00, 0), d);
    chk("R4 odd write 0x40", d, 8'hC3);
    rd1(8'hA3, d);
    chk("R4 odd read 0xA3", d, 8'h00);
    chk("R4 odd good no error", perr, 0);
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    xfer(8'h90, 3);
    chk("R4 parity mode burst advances", {rbuf[0], rbuf[1], rbuf[2]}, 24'h112233);
    rd1(8'hD0, d);
    chk("R5 odd mismatch sets flag", perr, 1);
    wr1(8'h7F, 8'h01); cur_mode = 2'b00;
    chk("R5 clear in odd mode", perr, 0);
    rd1(mk(1, 6'h3F, 0), d);
    chk("R7 control back to mode 00", d, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d, r;
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
    shift_byte(mk(0, 6'h05, 0), r);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    csn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 miso low with CS high", miso, 0);
    rd1(mk(1, 6'h05, 0), d);
    chk("R8 partial byte discarded", d, 8'hA5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst_step();
    t_burst_hold();
    t_wrap();
    t_even();
    t_odd();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule